// File: doc/BRIEF.md
# Debug DMA Memory Access Engine

This block sits on the target side of a debug link. It gives an external debugger a path into system memory that needs no help from the processor. The debugger sees three registers: an address register, a data register and a control register. Writing the control register with both the access-enable bit and the start bit set launches one single-beat transfer on a simple request/acknowledge memory bus. The transfer is a read or a write of byte, halfword or word size.

While the transfer is outstanding, the start bit reads back as 1. It falls to 0 when the bus answers. A bus error response, or a watchdog that runs out before any answer arrives, sets a sticky error bit. Only the next launch clears that bit.

Sub-word data stays in its natural byte lane, chosen by the low address bits. A read captures the full bus word into the data register. A write drives the data register onto the bus unchanged, and byte enables mark the lanes that are valid. The register port is a plain synchronous write port with a combinational read mux. Register select 0 is the address register, 1 is the data register and 2 is the control register. Select 3 reads as zero and ignores writes.

Top module: `dbgdma_engine`

## Requirements
- R1: After reset, the address, data and control registers all read 0, and `mem_req` is low.
- R2: When idle, writes to the address and data registers read back unchanged. The control register reads as {err[5], start[4], size[3:2], read_not_write[1], enable[0]}, where size 0 is byte, 1 is halfword and 2 is word. A control write stores enable, read_not_write and size.
- R3: A transfer starts only on an idle control write that has both bit 4 (start) and bit 0 (enable) set. A start without enable leaves `mem_req` low and the start bit at 0.
- R4: In the cycle after the launching write, `mem_req` rises and the start bit reads 1. Both stay high until `mem_ack` or `mem_err` is seen, and both are low in the following cycle.
- R5: A read (read_not_write=1) that completes with `mem_ack` and no `mem_err` stores the whole `mem_rdata` word into the data register, whatever the size code.
- R6: A write (read_not_write=0) drives `mem_we`=1, puts the data register unchanged on `mem_wdata`, and drives `mem_addr` as the address register with bits [1:0] forced to 0.
- R7: A byte transfer drives `mem_be` with the single bit selected by address bits [1:0]. Bit n covers data bits 8n+7:8n.
- R8: A halfword transfer drives `mem_be`=4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. A word transfer, or size code 3, drives 4'b1111.
- R9: A `mem_err` response sets the error bit (control bit 5) and leaves the data register unchanged. The bit survives later control writes that have the start bit at 0.
- R10: Launching a new transfer clears the error bit in the same cycle that `mem_req` rises.
- R11: While a transfer is in progress, writes to any register have no effect. The bus command stays stable, and the address, data and control contents are unchanged once the transfer ends.
- R12: With WDOG_CYCLES > 0, a transfer that gets no response is ended after exactly WDOG_CYCLES cycles of `mem_req`. The error bit is then set and the start bit clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 data, 2 control |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data of the selected register (combinational) |
| mem_req | output | 1 | Bus request, held until a response |
| mem_we | output | 1 | Bus write (1) or read (0) |
| mem_addr | output | AW | Word-aligned bus address |
| mem_be | output | DW/8 | Byte-lane enables |
| mem_wdata | output | DW | Bus write data |
| mem_rdata | input | DW | Bus read data, valid with mem_ack |
| mem_ack | input | 1 | Successful completion response |
| mem_err | input | 1 | Error completion response |

## Verification
A register write takes effect at the clock edge that samples it. A launch therefore shows `mem_req`, the bus command and a start bit of 1 one edge later. A response seen at edge k retires the transfer at that same edge, so the captured data, the cleared start bit and the error bit are all visible just after edge k. The watchdog ends an unanswered request after WDOG_CYCLES edges with `mem_req` high.

The bench drives every input on the falling edge and samples the combinational read port on the falling edge that follows each rising edge. Each check thus falls exactly one edge after its stimulus. The watchdog case counts the falling edges that see `mem_req` high and compares that count with WDOG_CYCLES.

// File: rtl/dbgdma_pkg.sv
package dbgdma_pkg;

    // Transfer size code held in the control register
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    // Register select codes on the debugger port
    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Control register bit positions
    localparam int CTL_EN    = 0;
    localparam int CTL_RNW   = 1;
    localparam int CTL_SZ_LO = 2;
    localparam int CTL_SZ_HI = 3;
    localparam int CTL_START = 4;
    localparam int CTL_ERR   = 5;

    // Outcome of one bus transfer
    typedef struct packed {
        logic done;
        logic failed;
    } xfer_result_t;

    // True when a size code covers every lane
    function automatic logic is_full_word(xfer_size_e sz);
        return (sz == SZ_WORD) || (sz == SZ_RSVD);
    endfunction

endpackage

// File: rtl/dbgdma_lanes.sv
module dbgdma_lanes
    import dbgdma_pkg::*;
#(
    parameter int DW = 32
) (
    input  xfer_size_e          size,
    input  logic [1:0]          addr_lo,
    output logic [DW/8-1:0]     be
);
    localparam int LANES = DW / 8;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [1:0] LANE_IDX = 2'(i);
        always_comb begin
            unique case (size)
                SZ_BYTE: be[i] = (addr_lo == LANE_IDX);
                SZ_HALF: be[i] = (addr_lo[1] == LANE_IDX[1]);
                default: be[i] = is_full_word(size);
            endcase
        end
    end

endmodule

// File: rtl/dbgdma_bus_fsm.sv
module dbgdma_bus_fsm
    import dbgdma_pkg::*;
#(
    parameter int WDOG_CYCLES = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         launch,
    input  logic         mem_ack,
    input  logic         mem_err,
    output logic         busy,
    output xfer_result_t result,
    output logic         wd_expire
);
    typedef enum logic {ST_IDLE, ST_WAIT} state_e;

    state_e state_q;

    assign busy          = (state_q == ST_WAIT);
    assign result.done   = busy && (mem_ack || mem_err || wd_expire);
    assign result.failed = busy && (mem_err || wd_expire);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (launch)      state_q <= ST_WAIT;
                ST_WAIT: if (result.done) state_q <= ST_IDLE;
                default:                  state_q <= ST_IDLE;
            endcase
        end
    end

    if (WDOG_CYCLES > 0) begin : g_wdog
        localparam int CW = $clog2(WDOG_CYCLES + 1);
        logic [CW-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
            end else if (launch) begin
                cnt_q <= '0;
            end else if (busy) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end

        assign wd_expire = busy && (cnt_q == CW'(WDOG_CYCLES - 1))
                           && !mem_ack && !mem_err;
    end else begin : g_no_wdog
        assign wd_expire = 1'b0;
    end

endmodule

// File: rtl/dbgdma_regs.sv
module dbgdma_regs
    import dbgdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          busy,
    input  xfer_result_t  result,
    input  logic [DW-1:0] bus_rdata,
    output logic          launch,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q,
    output logic          rnw_q,
    output xfer_size_e    size_q,
    output logic          err_q
);
    reg_sel_e sel;
    logic     wr_ok;
    logic     en_q;

    assign sel    = reg_sel_e'(reg_sel);
    assign wr_ok  = reg_we && !busy;
    assign launch = wr_ok && (sel == SEL_CTRL)
                    && reg_wdata[CTL_START] && reg_wdata[CTL_EN];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            en_q   <= 1'b0;
            rnw_q  <= 1'b0;
            size_q <= SZ_BYTE;
            err_q  <= 1'b0;
        end else begin
            if (wr_ok && sel == SEL_ADDR) begin
                addr_q <= reg_wdata[AW-1:0];
            end

            if (wr_ok && sel == SEL_DATA) begin
                data_q <= reg_wdata;
            end else if (result.done && !result.failed && rnw_q) begin
                data_q <= bus_rdata;
            end

            if (wr_ok && sel == SEL_CTRL) begin
                en_q   <= reg_wdata[CTL_EN];
                rnw_q  <= reg_wdata[CTL_RNW];
                size_q <= xfer_size_e'(reg_wdata[CTL_SZ_HI:CTL_SZ_LO]);
            end

            if (launch) begin
                err_q <= 1'b0;
            end else if (result.done && result.failed) begin
                err_q <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (sel)
            SEL_ADDR: reg_rdata = DW'(addr_q);
            SEL_DATA: reg_rdata = data_q;
            SEL_CTRL: reg_rdata = DW'({err_q, busy, size_q, rnw_q, en_q});
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dbgdma_engine.sv
module dbgdma_engine
    import dbgdma_pkg::*;
#(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int WDOG_CYCLES = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [1:0]      reg_sel,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW/8-1:0] mem_be,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_ack,
    input  logic            mem_err
);
    localparam int OFS = $clog2(DW / 8);

    logic          launch;
    logic          busy;
    logic          wd_expire;
    xfer_result_t  result;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          rnw_q;
    xfer_size_e    size_q;
    logic          err_flag;

    dbgdma_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .result    (result),
        .bus_rdata (mem_rdata),
        .launch    (launch),
        .addr_q    (addr_q),
        .data_q    (data_q),
        .rnw_q     (rnw_q),
        .size_q    (size_q),
        .err_q     (err_flag)
    );

    dbgdma_bus_fsm #(.WDOG_CYCLES(WDOG_CYCLES)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .busy      (busy),
        .result    (result),
        .wd_expire (wd_expire)
    );

    dbgdma_lanes #(.DW(DW)) u_lanes (
        .size    (size_q),
        .addr_lo (addr_q[1:0]),
        .be      (mem_be)
    );

    assign mem_req   = busy;
    assign mem_we    = !rnw_q;
    assign mem_addr  = {addr_q[AW-1:OFS], OFS'(0)};
    assign mem_wdata = data_q;

endmodule

// File: rtl/dbgdma_checker.sv
module dbgdma_checker
    import dbgdma_pkg::*;
#(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int WDOG_CYCLES = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            mem_req,
    input logic            mem_we,
    input logic [AW-1:0]   mem_addr,
    input logic [DW/8-1:0] mem_be,
    input logic [DW-1:0]   mem_wdata,
    input logic            mem_ack,
    input logic            mem_err,
    input logic            wd_expire,
    input logic            err_flag,
    input xfer_size_e      size_q
);
    logic waiting;
    assign waiting = mem_req && !mem_ack && !mem_err && !wd_expire;

    // R4: request is held until a response arrives
    p_hold_req_r4: assert property (@(posedge clk) disable iff (rst)
        waiting |=> mem_req);

    // R4: a response ends the request
    p_drop_req_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req && (mem_ack || mem_err) |=> !mem_req);

    // R11: the bus command stays put while the transfer waits
    p_stable_cmd_r11: assert property (@(posedge clk) disable iff (rst)
        waiting |=> $stable(mem_addr) && $stable(mem_be)
                    && $stable(mem_wdata) && $stable(mem_we));

    // R9: an error response raises the sticky flag
    p_err_sets_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_err |=> err_flag);

    // R10: a fresh launch starts with the flag clear
    p_err_clear_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> !err_flag);

    // R7: byte access enables one lane
    p_byte_lane_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req && size_q == SZ_BYTE |-> $countones(mem_be) == 1);

    // R8: halfword access enables two lanes, word enables all
    p_half_lanes_r8: assert property (@(posedge clk) disable iff (rst)
        mem_req && size_q == SZ_HALF |-> $countones(mem_be) == 2);
    p_word_lanes_r8: assert property (@(posedge clk) disable iff (rst)
        mem_req && is_full_word(size_q) |-> mem_be == '1);

    if (WDOG_CYCLES > 0) begin : g_wdog_chk
        localparam int CW = $clog2(WDOG_CYCLES + 2);
        logic [CW-1:0] run_q;
        always_ff @(posedge clk) begin
            if (rst || !mem_req) run_q <= '0;
            else if (run_q < CW'(WDOG_CYCLES)) run_q <= run_q + 1'b1;
        end
        // R12: no request outlives the watchdog window
        p_wdog_bound_r12: assert property (@(posedge clk) disable iff (rst)
            mem_req |-> run_q < CW'(WDOG_CYCLES));
    end

endmodule

bind dbgdma_engine dbgdma_checker #(
    .AW(AW), .DW(DW), .WDOG_CYCLES(WDOG_CYCLES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .wd_expire (wd_expire),
    .err_flag  (err_flag),
    .size_q    (size_q)
);

// File: tb/dbgdma_engine_bench.sv
`timescale 1ns/1ps
module dbgdma_engine_bench;
    localparam int WDOG = 16;

    localparam logic [31:0] C_EN = 32'h01, C_RD = 32'h02, C_HALF = 32'h04,
                            C_WORD = 32'h08, C_RSVD = 32'h0C, C_GO = 32'h10,
                            C_ERR = 32'h20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    dbgdma_engine #(.WDOG_CYCLES(WDOG)) u_dbgdma_engine (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_err(mem_err)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] sel, output logic [31:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic respond(logic ack, logic err, logic [31:0] d);
        mem_ack = ack; mem_err = err; mem_rdata = d;
        @(negedge clk);
        mem_ack = 1'b0; mem_err = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int s = 0; s < 3; s++) begin
            rd(2'(s), v);
            check("R1 reg after reset", v, 32'h0);
        end
        check("R1 mem_req after reset", 32'(mem_req), 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(2'd0, 32'h1000_0004);
        rd(2'd0, v); check("R2 address readback", v, 32'h1000_0004);
        wr(2'd1, 32'hA5A5_5A5A);
        rd(2'd1, v); check("R2 data readback", v, 32'hA5A5_5A5A);
        wr(2'd2, C_EN | C_RD | C_HALF);
        rd(2'd2, v); check("R2 control readback", v, 32'h0000_0007);
        check("R3 no launch without start", 32'(mem_req), 32'h0);
    endtask

    task automatic t_start_no_en();
        logic [31:0] v;
        wr(2'd2, C_GO | C_WORD);
        check("R3 start without enable mem_req", 32'(mem_req), 32'h0);
        rd(2'd2, v); check("R3 start without enable start bit", v & C_GO, 32'h0);
    endtask

    task automatic t_word_read();
        logic [31:0] v;
        wr(2'd0, 32'h2000_0008);
        wr(2'd2, C_EN | C_RD | C_WORD | C_GO);
        check("R4 req after launch", 32'(mem_req), 32'h1);
        rd(2'd2, v); check("R4 start bit while busy", v & C_GO, C_GO);
        check("R6 read drives mem_we=0", 32'(mem_we), 32'h0);
        check("R8 word enables", 32'(mem_be), 32'hF);
        repeat (3) @(negedge clk);
        check("R4 req held without response", 32'(mem_req), 32'h1);
        respond(1'b1, 1'b0, 32'hDEAD_BEEF);
        check("R4 req dropped after ack", 32'(mem_req), 32'h0);
        rd(2'd2, v); check("R4 start bit cleared", v & C_GO, 32'h0);
        rd(2'd1, v); check("R5 word read captured", v, 32'hDEAD_BEEF);
    endtask

    task automatic t_byte_write();
        for (int n = 0; n < 4; n++) begin
            wr(2'd0, 32'h3000_0000 + 32'(n));
            wr(2'd1, 32'h1122_3344);
            wr(2'd2, C_EN | C_GO);
            check("R6 write mem_we", 32'(mem_we), 32'h1);
            check("R6 write aligned addr", mem_addr, 32'h3000_0000);
            check("R6 write data in lane", mem_wdata, 32'h1122_3344);
            check("R7 byte lane enable", 32'(mem_be), 32'h1 << n);
            respond(1'b1, 1'b0, 32'h0);
        end
    endtask

    task automatic t_half_read();
        logic [31:0] v;
        wr(2'd0, 32'h4000_0000);
        wr(2'd2, C_EN | C_RD | C_HALF | C_GO);
        check("R8 low half enables", 32'(mem_be), 32'h3);
        respond(1'b1, 1'b0, 32'hCAFE_F00D);
        rd(2'd1, v); check("R5 half read keeps whole word", v, 32'hCAFE_F00D);
        wr(2'd0, 32'h4000_0002);
        wr(2'd2, C_EN | C_RD | C_HALF | C_GO);
        check("R8 high half enables", 32'(mem_be), 32'hC);
        respond(1'b1, 1'b0, 32'h0BAD_CAFE);
        wr(2'd2, C_EN | C_RD | C_RSVD | C_GO);
        check("R8 size code 3 enables", 32'(mem_be), 32'hF);
        respond(1'b1, 1'b0, 32'h1234_5678);
    endtask

    task automatic t_error();
        logic [31:0] v;
        wr(2'd1, 32'h5555_AAAA);
        wr(2'd2, C_EN | C_RD | C_WORD | C_GO);
        respond(1'b0, 1'b1, 32'hFFFF_FFFF);
        rd(2'd2, v); check("R9 error bit set", v & (C_ERR | C_GO), C_ERR);
        rd(2'd1, v); check("R9 data unchanged on error", v, 32'h5555_AAAA);
        wr(2'd2, C_EN);
        rd(2'd2, v); check("R9 error sticky", v, 32'h21);
        wr(2'd2, C_EN | C_RD | C_WORD | C_GO);
        rd(2'd2, v); check("R10 error cleared on launch", v & (C_ERR | C_GO), C_GO);
        respond(1'b1, 1'b0, 32'h0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        wr(2'd0, 32'h6000_0001);
        wr(2'd1, 32'h0000_7700);
        wr(2'd2, C_EN | C_GO);
        wr(2'd0, 32'h7000_0003);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd2, C_EN | C_RD | C_WORD | C_GO);
        check("R11 addr held while busy", mem_addr, 32'h6000_0000);
        check("R11 be held while busy", 32'(mem_be), 32'h2);
        check("R11 wdata held while busy", mem_wdata, 32'h0000_7700);
        respond(1'b1, 1'b0, 32'h0);
        rd(2'd0, v); check("R11 address reg unchanged", v, 32'h6000_0001);
        rd(2'd1, v); check("R11 data reg unchanged", v, 32'h0000_7700);
        rd(2'd2, v); check("R11 control reg unchanged", v, 32'h01);
        @(negedge clk);
        check("R11 no second launch", 32'(mem_req), 32'h0);
    endtask

    task automatic t_wdog();
        logic [31:0] v;
        int cnt = 0;
        wr(2'd2, C_EN | C_RD | C_WORD | C_GO);
        while (mem_req && cnt < 100) begin
            cnt++;
            @(negedge clk);
        end
        check("R12 watchdog request length", 32'(cnt), 32'(WDOG));
        rd(2'd2, v); check("R12 watchdog sets error", v & (C_ERR | C_GO), C_ERR);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_start_no_en();
        t_word_read();
        t_byte_write();
        t_half_read();
        t_error();
        t_busy_ignore();
        t_wdog();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule